// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM of 32768 bytes. The host issues one request at a time: a read or a write, with a 15-bit address and an 8-bit data byte. The block turns that request into chip-select, write-strobe and output-strobe waveforms whose widths are counted in clock cycles. The counts come from the clock period and the memory's timing figures, which are given as parameters in picoseconds. When the request completes, the block raises a one-cycle completion pulse, and for a read it returns the captured byte.

The memory data pins are shared in both directions, so the block presents them as three separate signals: a driven value, a drive enable and a sampled value. During a write the output strobe stays inactive, so the memory never drives the pins while write data is applied. After every read, a recovery window keeps the device deselected for long enough that the memory has released the pins before anything else can happen. Between requests the chip select is held inactive, which lets the memory drop into its low-power state.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever no request is in progress, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and req_ready is 1.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the following cycle until the cycle in which rsp_done is 1. rsp_done is a single-cycle pulse, and there is exactly one pulse per request.
- R3: A write first spends one setup cycle with mem_ce_n=0, mem_we_n=1 and the data driven (mem_dq_oe=1). Next comes the write pulse with mem_we_n=0. Then follows one hold cycle with mem_we_n=1 and the data still driven. mem_oe_n stays 1 throughout the write.
- R4: The write pulse lasts exactly ceil(WR_PS/CLK_PS) cycles, with a minimum of 1. With CLK_PS=4000 and WR_PS=45000, that is 12 cycles.
- R5: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly ceil(ACC_PS/CLK_PS) cycles, with a minimum of 1. With ACC_PS=70000 and CLK_PS=4000, that is 18 cycles. mem_dq_oe stays 0 during the read. rsp_rdata is taken from mem_dq_i at the clock edge that ends the last of those cycles.
- R6: After a read's strobes are released, the device stays fully deselected for ceil(HZ_PS/CLK_PS) cycles before rsp_done, with a minimum of 1. With HZ_PS=25000, that is 7 cycles. mem_dq_oe is never 1 while mem_oe_n is 0.
- R7: mem_addr equals the accepted request address, and it stays stable for as long as mem_ce_n is 0.
- R8: rsp_rdata changes only as the result of a read capture. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_o | output | 8 | Value driven onto the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_i | input | 8 | Value sampled from the data pins |

## Verification
The bench uses a memory model with three timing behaviours. It returns inverted data until the access time has elapsed, so a capture made one cycle early is caught. It keeps driving the pins for the release interval after a read, so a shortened recovery shows up as bus contention. It also measures every write-pulse width and setup/hold cycle. The traffic starts with directed extremes: the lowest and highest addresses, the all-zero and all-one bytes, and alternating-bit patterns. These expose address or data bit faults. It then runs a read immediately followed by a write, which separates a correct turnaround from one that drives too early. Random mixed traffic on a small address window then exercises read-after-write hits. Write completions also confirm that the returned read byte does not move.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WHOLD  = 3'd3,
        ST_RACC   = 3'd4,
        ST_RTURN  = 3'd5
    } sram_st_e;

    // Cycles needed to cover a time span, never fewer than one.
    function automatic int unsigned span_cycles(int unsigned span_ps, int unsigned clk_ps);
        int unsigned c;
        c = (span_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int RD_CYC = 18,
    parameter int WR_CYC = 12,
    parameter int HZ_CYC = 7,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_zero
);
    typedef struct packed {
        sram_st_e          state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        state: ST_IDLE, addr: '0, wdata: '0, rdata: '0, done: 1'b0,
        ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0
    };

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    if (req_write) begin
                        r_d.state = ST_WSETUP;
                    end else begin
                        r_d.state = ST_RACC;
                        cnt_load  = 1'b1;
                        cnt_val   = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_WSETUP: begin
                r_d.state = ST_WPULSE;
                cnt_load  = 1'b1;
                cnt_val   = CNT_W'(WR_CYC - 1);
            end
            ST_WPULSE: begin
                if (cnt_zero) r_d.state = ST_WHOLD;
            end
            ST_WHOLD: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
            ST_RACC: begin
                if (cnt_zero) begin
                    r_d.rdata = mem_dq_i;
                    r_d.state = ST_RTURN;
                    cnt_load  = 1'b1;
                    cnt_val   = CNT_W'(HZ_CYC - 1);
                end
            end
            ST_RTURN: begin
                if (cnt_zero) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        // Strobes are registered alongside the state they belong to.
        r_d.ce_n  = (r_d.state == ST_IDLE) || (r_d.state == ST_RTURN);
        r_d.we_n  = (r_d.state != ST_WPULSE);
        r_d.oe_n  = (r_d.state != ST_RACC);
        r_d.dq_oe = (r_d.state == ST_WSETUP) || (r_d.state == ST_WPULSE) ||
                    (r_d.state == ST_WHOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign rsp_done  = r_q.done;
    assign rsp_rdata = r_q.rdata;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_addr  = r_q.addr;
    assign mem_dq_o  = r_q.wdata;
    assign mem_dq_oe = r_q.dq_oe;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int CLK_PS = 10000,
    parameter int ACC_PS = 70000,
    parameter int WR_PS  = 45000,
    parameter int HZ_PS  = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int RD_CYC = int'(span_cycles(ACC_PS, CLK_PS));
    localparam int WR_CYC = int'(span_cycles(WR_PS, CLK_PS));
    localparam int HZ_CYC = int'(span_cycles(HZ_PS, CLK_PS));
    localparam int MAX_A  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int MAX_C  = (MAX_A > HZ_CYC) ? MAX_A : HZ_CYC;
    localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;

    sram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    sram_ctl_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC),
        .WR_CYC(WR_CYC), .HZ_CYC(HZ_CYC), .CNT_W(CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .cnt_zero  (cnt_zero)
    );
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe
);
    p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_we_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n));

    p_we_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe));

    p_no_fight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    p_turn_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> !mem_dq_oe);

    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_rdata_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_rdata) |-> $past(!mem_oe_n));
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;
    localparam int NRD = 18;   // ceil(70000/4000)
    localparam int NWR = 12;   // ceil(45000/4000)
    localparam int NHZ = 7;    // ceil(25000/4000)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [7:0]  rsp_rdata;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_o, mem_dq_i;

    int checks = 0;
    int errors = 0;
    int contention = 0;

    always #2 clk = ~clk;

    sram_ctl #(.CLK_PS(4000), .ACC_PS(70000), .WR_PS(45000), .HZ_PS(25000)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [7:0] mem [int];
    logic [7:0] refm [int];
    int rd_age = 0;
    int hz_left = 0;

    function automatic logic [7:0] blank(input logic [14:0] a);
        return ~a[7:0];
    endfunction

    function automatic logic [7:0] mem_rd(input logic [14:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : blank(a);
    endfunction

    wire rd_cond = !mem_ce_n && !mem_oe_n && mem_we_n;
    wire mem_drv = rd_cond || (hz_left > 0);

    assign mem_dq_i = !mem_drv ? 8'hzz :
                      (rd_cond && rd_age >= NRD - 1) ? mem_rd(mem_addr) : ~mem_rd(mem_addr);

    always @(posedge clk) begin
        if (rd_cond) begin
            rd_age  <= rd_age + 1;
            hz_left <= NHZ;
        end else begin
            rd_age  <= 0;
            if (hz_left > 0) hz_left <= hz_left - 1;
        end
        if (!mem_ce_n && !mem_we_n) mem[int'(mem_addr)] = mem_dq_o;
    end

    // ---------------- write-timing and contention monitor ----------------
    int   wlen = 0;
    logic prev_dq_oe = 1'b0;
    logic [14:0] cur_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_drv && mem_dq_oe) contention++;
            if (!mem_we_n) begin
                if (wlen == 0) begin
                    chk(prev_dq_oe == 1'b1, "R3 setup cycle drives data", prev_dq_oe, 1);
                    chk(mem_oe_n == 1'b1, "R3 oe_n high during write", mem_oe_n, 1);
                end
                wlen++;
            end else if (wlen != 0) begin
                chk(wlen == NWR, "R4 write pulse width", wlen, NWR);
                chk(mem_dq_oe && !mem_ce_n, "R3 hold cycle", {mem_dq_oe, mem_ce_n}, 2'b10);
                chk(mem_addr == cur_addr, "R7 write address", mem_addr, cur_addr);
                wlen = 0;
            end
            prev_dq_oe = mem_dq_oe;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit         is_rd;
        logic [7:0] data;
    } exp_t;
    exp_t q[$];
    logic [7:0] last_rd = '0;
    int done_cnt = 0;

    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            done_cnt++;
            chk(req_ready && mem_ce_n, "R1 idle after done", {req_ready, mem_ce_n}, 2'b11);
            if (q.size() == 0) begin
                chk(1'b0, "R2 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.is_rd) begin
                    chk(rsp_rdata == e.data, "R5 read data", rsp_rdata, e.data);
                    last_rd = e.data;
                end else begin
                    chk(rsp_rdata == last_rd, "R8 rdata kept on write", rsp_rdata, last_rd);
                end
            end
        end
    end

    task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
        exp_t e;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        cur_addr  = a;
        e.is_rd = !wr;
        if (wr) begin
            refm[int'(a)] = d;
            e.data = 8'h00;
        end else begin
            e.data = refm.exists(int'(a)) ? refm[int'(a)] : blank(a);
        end
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    endtask

    task automatic read_timing(input logic [14:0] a);
        int lo;
        do_op(1'b0, a, 8'h00);
        lo = 1;  // first read-strobe cycle already passed at this negedge
        while (!mem_oe_n) begin
            chk(mem_dq_oe == 1'b0, "R5 no drive during read", mem_dq_oe, 0);
            @(negedge clk);
            if (!mem_oe_n) lo++;
        end
        chk(lo == NRD, "R5 read strobe width", lo, NRD);
        lo = 0;
        while (!rsp_done) begin
            chk(mem_ce_n == 1'b1, "R6 deselected in recovery", mem_ce_n, 1);
            lo++;
            @(negedge clk);
        end
        chk(lo == NHZ, "R6 recovery length", lo, NHZ);
    endtask

    initial begin
        #(4.0 * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ops;
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 reset strobes", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        chk(mem_dq_oe == 1'b0, "R1 reset drive", mem_dq_oe, 0);
        chk(req_ready == 1'b1 && rsp_done == 1'b0, "R1 R2 reset handshake", {req_ready, rsp_done}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n == 1'b1, "R1 idle deselect", mem_ce_n, 1);

        // directed extremes
        do_op(1'b1, 15'h0000, 8'h00);
        do_op(1'b1, 15'h7FFF, 8'hFF);
        do_op(1'b1, 15'h2AAA, 8'h55);
        do_op(1'b1, 15'h5555, 8'hAA);
        read_timing(15'h0000);
        do_op(1'b0, 15'h7FFF, 8'h00);
        do_op(1'b0, 15'h2AAA, 8'h00);
        do_op(1'b0, 15'h5555, 8'h00);
        do_op(1'b0, 15'h0F0F, 8'h00);  // never written
        // read then write back-to-back, then verify
        do_op(1'b0, 15'h7FFF, 8'h00);
        do_op(1'b1, 15'h7FFF, 8'h3C);
        do_op(1'b0, 15'h7FFF, 8'h00);
        // random mixed traffic in a small window
        for (int i = 0; i < 150; i++)
            do_op($urandom_range(0, 1) == 1, 15'($urandom_range(0, 15)), 8'($urandom));
        ops = 4 + 1 + 7 + 150;
        while (q.size() != 0) @(negedge clk);
        repeat (NHZ + 4) @(negedge clk);
        chk(done_cnt == ops, "R2 one done per request", done_cnt, ops);
        chk(contention == 0, "R6 bus contention", contention, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule